// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Timeslot-0 Formatter

This block produces the timeslot-0 byte of every outgoing E1 frame when the CRC-4 multiframe structure is in use. It counts frame positions through a 16-frame multiframe. The multiframe is split into two submultiframes of eight frames each. Even frames get a CRC bit and the frame alignment word. Odd frames get the multiframe alignment pattern or an E bit, a fixed one, the remote alarm bit and the five national spare bits.

While a submultiframe is being sent, the block accumulates a CRC-4 remainder over all of its bits. These are the timeslot-0 bytes, with the CRC positions counted as zero, and the payload bits that the surrounding transmitter feeds in serially. That remainder goes out in the next submultiframe. The receive side reports the CRC result of each received submultiframe. Those reports drive the E bits. They can also invert the outgoing CRC bits, and a separate control can force the inversion.

Top module: `e1_ts0_fmt`

## Requirements
- R1: While reset is active and until the first `frm_start`, `ts0_vld` is 0, `frame_idx` is 0 and `ts0_byte` is 0. The first frame after reset is frame 0.
- R2: Each `frm_start` pulse makes `ts0_vld` high for exactly the next cycle. `frame_idx` then shows the frame number, which goes up by one per frame and wraps from 15 to 0. `ts0_vld` is low in all other cycles.
- R3: In even frames, `ts0_byte[6:0]` is 7'b0011011 and `ts0_byte[7]` (bit 1 on the line, which is sent first) is a CRC bit.
- R4: The CRC uses x^4+x+1 and is the remainder of M(x)·x^4, taken MSB-first. M covers each submultiframe (frames 0–7 or 8–15) as follows: each frame's timeslot-0 byte, with bit 7 of even frames taken as 0, is followed by the payload bits given with `pay_vld` in the cycles before the next `frm_start`. Payload is accepted only in cycles without `frm_start`. The remainder, MSB first, appears as the CRC bit in frames 0, 2, 4 and 6 of the following submultiframe (8, 10, 12, 14 respectively). The submultiframe that starts right after reset sends 0000.
- R5: The invert condition is `(inv_auto_en & last reported receive error) | inv_force`. It is evaluated at the `frm_start` of frame 0 or 8. If it is true, all four CRC bits of that submultiframe are sent inverted.
- R6: In frames 1, 3, 5, 7, 9 and 11, `ts0_byte[7]` is 0, 0, 1, 0, 1, 1 respectively.
- R7: In frame 13, `ts0_byte[7]` is the inverse of the last error reported for received submultiframe I (`rx_rep_smf`=0). In frame 15 it is the inverse of the last error reported for submultiframe II (`rx_rep_smf`=1). After reset both E bits are 1.
- R8: In odd frames, `ts0_byte[6]` is 1, `ts0_byte[5]` is `a_bit`, and `ts0_byte[4:0]` is `sa_bits`, with `sa_bits[4]` carrying Sa4 and `sa_bits[0]` carrying Sa8. These inputs are sampled at `frm_start`.
- R9: `ts0_byte` does not change between `frm_start` pulses, even when `a_bit` or `sa_bits` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Start of a new outgoing frame |
| pay_vld | input | 1 | A payload bit is present |
| pay_bit | input | 1 | Payload bit, frame order |
| rx_rep | input | 1 | Receive side reports a submultiframe CRC result |
| rx_rep_smf | input | 1 | Reported submultiframe: 0 = I, 1 = II |
| rx_rep_err | input | 1 | 1 = reported submultiframe had a CRC error |
| inv_auto_en | input | 1 | Enables CRC inversion on reported receive error |
| inv_force | input | 1 | Forces CRC inversion |
| a_bit | input | 1 | Remote alarm bit value |
| sa_bits | input | 5 | Sa4..Sa8 values, Sa4 in bit 4 |
| ts0_byte | output | 8 | Timeslot-0 byte, bit 7 sent first |
| ts0_vld | output | 1 | `ts0_byte` and `frame_idx` updated this cycle |
| frame_idx | output | 4 | Frame number of `ts0_byte` |

## Verification
The payload is tried all zeros, all ones and as a pseudo-random stream, and the per-frame payload length varies. All-zero payload checks that the timeslot-0 bits alone are covered by the CRC. All-ones and random payload show whether every payload bit enters the remainder in the right order and whether the remainder is placed in the right submultiframe. The invert cases come in a set: automatic inversion with a reported error, automatic inversion enabled with no error, forced inversion alone, and both off. Together they separate the OR from either term alone and show that the decision is held for a whole submultiframe. Error reports for each submultiframe, several multiframe wraps and `a_bit`/`sa_bits` changes in the middle of a frame cover the E bits, the counter wrap and the hold of the output byte.

// File: rtl/e1_ts0_fmt.sv
module e1_ts0_fmt #(
  parameter int SA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_start,
  input  logic            pay_vld,
  input  logic            pay_bit,
  input  logic            rx_rep,
  input  logic            rx_rep_smf,
  input  logic            rx_rep_err,
  input  logic            inv_auto_en,
  input  logic            inv_force,
  input  logic            a_bit,
  input  logic [SA_W-1:0] sa_bits,
  output logic [7:0]      ts0_byte,
  output logic            ts0_vld,
  output logic [3:0]      frame_idx
);
  localparam logic [6:0] FAS = 7'b0011011;

  logic [3:0] fcnt, crc, crc_hold;
  logic       inv_hold, last_err;
  logic [1:0] e_err;
  logic       c_bit, odd_b1;

  function automatic logic [3:0] crc_step(input logic [3:0] r, input logic b);
    logic fb;
    fb = r[3] ^ b;
    return {r[2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

  function automatic logic [3:0] crc_byte(input logic [3:0] r, input logic [7:0] d);
    logic [3:0] t;
    t = r;
    for (int i = 7; i >= 0; i--) t = crc_step(t, d[i]);
    return t;
  endfunction

  wire       smf_start = (fcnt[2:0] == 3'd0);
  wire [3:0] send_crc  = smf_start ? crc : crc_hold;
  wire       send_inv  = smf_start ? ((inv_auto_en & last_err) | inv_force) : inv_hold;

  always_comb begin
    case (fcnt[2:1])
      2'd0:    c_bit = send_crc[3];
      2'd1:    c_bit = send_crc[2];
      2'd2:    c_bit = send_crc[1];
      default: c_bit = send_crc[0];
    endcase
  end

  always_comb begin
    case (fcnt)
      4'd5, 4'd9, 4'd11: odd_b1 = 1'b1;
      4'd13:             odd_b1 = ~e_err[0];
      4'd15:             odd_b1 = ~e_err[1];
      default:           odd_b1 = 1'b0;
    endcase
  end

  wire [7:0] next_byte = fcnt[0] ? {odd_b1, 1'b1, a_bit, sa_bits} : {c_bit ^ send_inv, FAS};
  wire [7:0] fold_byte = fcnt[0] ? next_byte : {1'b0, FAS};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt      <= '0;
      crc       <= '0;
      crc_hold  <= '0;
      inv_hold  <= 1'b0;
      ts0_byte  <= '0;
      ts0_vld   <= 1'b0;
      frame_idx <= '0;
    end else if (frm_start) begin
      ts0_byte  <= next_byte;
      ts0_vld   <= 1'b1;
      frame_idx <= fcnt;
      fcnt      <= fcnt + 4'd1;
      inv_hold  <= send_inv;
      crc       <= crc_byte(smf_start ? 4'd0 : crc, fold_byte);
      if (smf_start) crc_hold <= crc;
    end else begin
      ts0_vld <= 1'b0;
      if (pay_vld) crc <= crc_step(crc, pay_bit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_err    <= '0;
      last_err <= 1'b0;
    end else if (rx_rep) begin
      e_err[rx_rep_smf] <= rx_rep_err;
      last_err          <= rx_rep_err;
    end
  end
endmodule

// File: rtl/e1_ts0_fmt_chk.sv
module e1_ts0_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_start,
  input logic [7:0] ts0_byte,
  input logic       ts0_vld,
  input logic [3:0] frame_idx
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (frm_start) seen <= 1'b1;
  end

  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> ts0_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> !ts0_vld);
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && seen) |=> frame_idx == $past(frame_idx) + 4'd1);
  p_fas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_vld && !frame_idx[0]) |-> ts0_byte[6:0] == 7'b0011011);
  p_mfas_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_vld && (frame_idx == 4'd1 || frame_idx == 4'd3 || frame_idx == 4'd7)) |-> !ts0_byte[7]);
  p_mfas_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_vld && (frame_idx == 4'd5 || frame_idx == 4'd9 || frame_idx == 4'd11)) |-> ts0_byte[7]);
  p_odd_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_vld && frame_idx[0]) |-> ts0_byte[6]);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> $stable(ts0_byte));
endmodule

bind e1_ts0_fmt e1_ts0_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
  .ts0_byte(ts0_byte), .ts0_vld(ts0_vld), .frame_idx(frame_idx)
);

// File: tb/e1_ts0_fmt_test.sv
`timescale 1ns/1ps
module e1_ts0_fmt_test;
  logic clk = 0, rst_n = 0;
  logic frm_start = 0, pay_vld = 0, pay_bit = 0;
  logic rx_rep = 0, rx_rep_smf = 0, rx_rep_err = 0;
  logic inv_auto_en = 0, inv_force = 0, a_bit = 0;
  logic [4:0] sa_bits = 0;
  logic [7:0] ts0_byte;
  logic ts0_vld;
  logic [3:0] frame_idx;

  always #10 clk = ~clk;

  e1_ts0_fmt uut (.*);

  typedef struct { logic [7:0] b; int idx; bit inv; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  int fc = 0;
  bit smf[$];
  logic [3:0] hold = 0;
  bit invh = 0, lasterr = 0;
  bit eerr[2] = '{0, 0};
  logic [15:0] lf = 16'hACE1;
  logic [7:0] last_exp = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] rem_of(bit m[$]);
    bit a[$];
    int n;
    a = m;
    repeat (4) a.push_back(0);
    n = a.size();
    for (int i = 0; i + 4 < n; i++)
      if (a[i]) begin
        a[i] = 0; a[i+3] = ~a[i+3]; a[i+4] = ~a[i+4];
      end
    return {a[n-4], a[n-3], a[n-2], a[n-1]};
  endfunction

  function automatic bit nextr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic rx_report(bit s, bit e);
    @(negedge clk);
    rx_rep = 1; rx_rep_smf = s; rx_rep_err = e;
    eerr[s] = e; lasterr = e;
    @(negedge clk);
    rx_rep = 0;
  endtask

  task automatic send_frame(int npay, int mode);
    exp_t it;
    logic [7:0] zb;
    bit b1;
    int idx = fc;
    @(negedge clk);
    a_bit = idx[1];
    sa_bits = {idx[3:0], idx[0]} ^ 5'b10110;
    if (idx % 8 == 0) begin
      hold = rem_of(smf);
      smf.delete();
      invh = (inv_auto_en & lasterr) | inv_force;
    end
    if (idx % 2 == 0) begin
      it.b = {hold[3 - (idx % 8) / 2] ^ invh, 7'b0011011};
      zb = {1'b0, 7'b0011011};
    end else begin
      case (idx)
        5, 9, 11: b1 = 1;
        13: b1 = ~eerr[0];
        15: b1 = ~eerr[1];
        default: b1 = 0;
      endcase
      it.b = {b1, 1'b1, a_bit, sa_bits};
      zb = it.b;
    end
    it.idx = idx; it.inv = invh;
    for (int i = 7; i >= 0; i--) smf.push_back(zb[i]);
    q.push_back(it);
    last_exp = it.b;
    frm_start = 1;
    @(negedge clk);
    frm_start = 0;
    for (int i = 0; i < npay; i++) begin
      bit pb;
      pb = (mode == 0) ? 0 : (mode == 1) ? 1 : nextr();
      pay_vld = 1; pay_bit = pb;
      smf.push_back(pb);
      @(negedge clk);
    end
    pay_vld = 0;
    a_bit = ~a_bit; sa_bits = ~sa_bits;
    @(negedge clk);
    chk(ts0_byte == last_exp, "R9 hold", ts0_byte, last_exp);
    fc = (fc + 1) % 16;
  endtask

  always @(negedge clk) begin
    if (rst_n && ts0_vld) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R2 unexpected vld", 1, 0);
      else begin
        e = q.pop_front();
        chk(frame_idx == e.idx[3:0], "R2 frame_idx", frame_idx, e.idx);
        if (e.idx % 2 == 0) begin
          chk(ts0_byte[6:0] == e.b[6:0], "R3 FAS", ts0_byte[6:0], e.b[6:0]);
          chk(ts0_byte[7] == e.b[7], e.inv ? "R5 inverted C bit" : "R4 C bit", ts0_byte[7], e.b[7]);
        end else begin
          chk(ts0_byte[7] == e.b[7], (e.idx >= 13) ? "R7 E bit" : "R6 MFAS", ts0_byte[7], e.b[7]);
          chk(ts0_byte[6:0] == e.b[6:0], "R8 A/Sa", ts0_byte[6:0], e.b[6:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ts0_vld == 0, "R1 vld", ts0_vld, 0);
    chk(frame_idx == 0, "R1 idx", frame_idx, 0);
    chk(ts0_byte == 0, "R1 byte", ts0_byte, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(ts0_vld == 0 && ts0_byte == 0, "R1 after reset", ts0_byte, 0);
    for (int f = 0; f < 16; f++) send_frame(12, 0);
    for (int f = 0; f < 16; f++) begin
      send_frame(9, 1);
      if (f == 3) rx_report(0, 1);
      if (f == 10) rx_report(1, 1);
    end
    inv_auto_en = 1;
    for (int f = 0; f < 16; f++) send_frame(7 + f, 2);
    rx_report(1, 0);
    for (int f = 0; f < 16; f++) send_frame(10, 2);
    inv_auto_en = 0; inv_force = 1;
    for (int f = 0; f < 16; f++) send_frame(5, 2);
    inv_force = 0;
    rx_report(0, 0);
    for (int f = 0; f < 20; f++) send_frame(11, 2);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 pending items", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule